// File: doc/BRIEF.md
# Sampling Tap Tuning Selector

After a tuning sweep of the receive sampling clock, this block chooses the phase tap to use. Each tap is probed twice, and a pass/fail result arrives for every probe. A tap is usable only when both of its probes passed. The block looks for the longest unbroken window of usable taps, and a window may wrap past the last tap to the first. It then returns the tap at the centre of that window. If no window is long enough, it reports that tuning failed.

A host opens a sweep with a begin strobe, which also selects the tap count: eight taps normally, or four in the 400 double-data-rate mode. The host then feeds the results in probe order and asks for a selection. The selector examines one result entry per clock and ends with a one-cycle done pulse.

When a selection succeeds, the block loads the chosen tap into its tap register and turns on automatic retuning. While retuning is on, it also latches a retune error from the sampling checker into a flag, which the host clears.

Top module: `tts_tap_tuner`

## Requirements
- R1: After reset the outputs are as follows: `busy`, `done`, `tune_ok`, `retune_en` and `err_flag` are all 0, and `tap_sel` is 0.
- R2: A `sweep_begin` taken while idle does four things. It empties the stored results, restarts the result position at 0, latches `mode_ddr` (1 means N=4 taps, 0 means N=8), and clears `retune_en`. Each later idle cycle with `res_valid` stores `res_pass` at the next position. Positions 0..N-1 hold the first sweep of taps 0..N-1, and positions N..2N-1 hold the second sweep. Results beyond position 2N-1 are ignored. `sweep_begin` has priority over `res_valid` and `select_go` in the same cycle.
- R3: Position i counts as passing only if tap (i mod N) passed in both sweeps.
- R4: A `select_go` taken while idle holds `busy` high for exactly 2N+1 cycles. A one-cycle `done` pulse follows in the cycle right after `busy` falls.
- R5: The longest run of consecutive passing positions is searched over all 2N positions. Among runs of equal length, the one with the lowest start wins. A run that reaches position 2N-1 is also counted.
- R6: If the longest run has at least 3 positions, let s be its first position and e its last. Then `tune_ok` is 1, `tap_sel` becomes ((s+e)/2) mod N, and `retune_en` becomes 1. All three take effect in the `done` cycle.
- R7: If the longest run is shorter than 3, `tune_ok` is 0, `tap_sel` keeps its previous value, and `retune_en` stays 0.
- R8: A cycle with `err_in` sets `err_flag` only when `retune_en` is 1 and the latched mode is the eight-tap one. Otherwise `err_in` has no effect.
- R9: `err_clr` clears `err_flag`. If `err_clr` and a qualifying `err_in` arrive in the same cycle, the flag is set.
- R10: While `busy` is high, `sweep_begin`, `res_valid` and `select_go` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sweep_begin | input | 1 | Opens a new sweep and latches the mode |
| mode_ddr | input | 1 | 1: four-tap 400 DDR mode, 0: eight-tap mode |
| res_valid | input | 1 | A probe result is present |
| res_pass | input | 1 | The probe passed |
| select_go | input | 1 | Start the window search |
| err_in | input | 1 | Retune error pulse from the sampling checker |
| err_clr | input | 1 | Host write of zero to the error flag |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| tune_ok | output | 1 | The last search found a long enough window |
| tap_sel | output | $clog2(TAPS_NORM) | Selected sampling tap |
| retune_en | output | 1 | Automatic retuning enabled |
| err_flag | output | 1 | Latched retune error |

## Verification
Two things can happen in the same cycle: a retune error arriving and the host clearing the flag. The bench drives `err_in` and `err_clr` on the same edge while retuning is enabled and expects the flag to end up set. It then clears the flag on its own and expects it to end up clear. A second coincidence is a successful `done` that turns on retuning in the same cycle as an `err_in`. The bench judges this case against its own per-cycle model, in which the error is gated by the retune state from before that edge.

// File: rtl/tts_pkg.sv
package tts_pkg;
    // Controller phases of the window search
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIN  = 2'd2
    } tts_state_e;
endpackage

// File: rtl/tts_bitmap.sv
// Stores the 2*TAPS_NORM raw probe results and presents the merged
// (both-sweeps-passed) value of one position per cycle.
// Assumes TAPS_DDR <= TAPS_NORM and that wr_idx stays below the active span.
module tts_bitmap #(
    parameter int TAPS_NORM = 8,
    parameter int TAPS_DDR  = 4,
    parameter int CW        = $clog2(2*TAPS_NORM+1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_idx,
    input  logic          wr_bit,
    input  logic          ddr,
    input  logic [CW-1:0] rd_idx,
    output logic          rd_good
);
    localparam int ENT = 2*TAPS_NORM;
    localparam int IW  = $clog2(ENT);

    logic [ENT-1:0] raw;
    logic [ENT-1:0] mg_norm;
    logic [ENT-1:0] mg_ddr;

    // Raw result storage, emptied at the start of a sweep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw <= '0;
        end else if (clr) begin
            raw <= '0;
        end else if (wr_en) begin
            raw[wr_idx[IW-1:0]] <= wr_bit;
        end
    end

    // Merge the two sweeps for each tap count variant
    for (genvar g = 0; g < ENT; g++) begin : g_merge
        assign mg_norm[g] = raw[g % TAPS_NORM] & raw[(g % TAPS_NORM) + TAPS_NORM];
        if (g < 2*TAPS_DDR) begin : g_ddr
            assign mg_ddr[g] = raw[g % TAPS_DDR] & raw[(g % TAPS_DDR) + TAPS_DDR];
        end else begin : g_pad
            assign mg_ddr[g] = 1'b0;
        end
    end

    // Merged value at the position under scan
    always_comb begin
        rd_good = ddr ? mg_ddr[rd_idx[IW-1:0]] : mg_norm[rd_idx[IW-1:0]];
    end
endmodule

// File: rtl/tts_scan.sv
// Tracks the current and the best run of passing positions, one position per
// step, and derives the centre tap of the best run including a run that is
// still open at the end of the map. Assumes clr precedes the first step.
module tts_scan #(
    parameter int TAPS_NORM = 8,
    parameter int TAPS_DDR  = 4,
    parameter int CW        = $clog2(2*TAPS_NORM+1),
    parameter int TW        = $clog2(TAPS_NORM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic          bit_in,
    input  logic [CW-1:0] idx,
    input  logic          ddr,
    output logic [CW-1:0] win_len,
    output logic [TW-1:0] centre
);
    localparam logic [CW-1:0] SPAN_N = CW'(2*TAPS_NORM);
    localparam logic [CW-1:0] SPAN_D = CW'(2*TAPS_DDR);
    localparam logic [CW:0]   MOD_N  = (CW+1)'(TAPS_NORM);
    localparam logic [CW:0]   MOD_D  = (CW+1)'(TAPS_DDR);

    logic [CW-1:0] run_q, best_len, best_st, best_en;
    logic [CW-1:0] span, fin_st, fin_en;
    logic [CW:0]   sum_w, half_w, mod_w;

    // Run tracking: a closed run replaces the best only when strictly longer
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q    <= '0;
            best_len <= '0;
            best_st  <= '0;
            best_en  <= '0;
        end else if (step) begin
            if (bit_in) begin
                run_q <= run_q + 1'b1;
            end else begin
                if (run_q > best_len) begin
                    best_len <= run_q;
                    best_st  <= idx - run_q;
                    best_en  <= idx - 1'b1;
                end
                run_q <= '0;
            end
        end
    end

    // Close a run left open at the last position and compute the centre
    always_comb begin
        span = ddr ? SPAN_D : SPAN_N;
        if (run_q > best_len) begin
            win_len = run_q;
            fin_st  = span - run_q;
            fin_en  = span - 1'b1;
        end else begin
            win_len = best_len;
            fin_st  = best_st;
            fin_en  = best_en;
        end
        sum_w  = {1'b0, fin_st} + {1'b0, fin_en};
        half_w = sum_w >> 1;
        mod_w  = ddr ? (half_w % MOD_D) : (half_w % MOD_N);
        centre = mod_w[TW-1:0];
    end
endmodule

// File: rtl/tts_retune.sv
// Holds the automatic retune enable and the latched retune error flag.
// Assumes clr_en and set_en never arrive in the same cycle.
module tts_retune (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_en,
    input  logic set_en,
    input  logic ddr,
    input  logic err_in,
    input  logic err_clr,
    output logic retune_en,
    output logic err_flag
);
    // Retune enable: dropped at a new sweep, raised by a good selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retune_en <= 1'b0;
        end else if (clr_en) begin
            retune_en <= 1'b0;
        end else if (set_en) begin
            retune_en <= 1'b1;
        end
    end

    // Error flag: a qualifying event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (err_in && retune_en && !ddr) begin
            err_flag <= 1'b1;
        end else if (err_clr) begin
            err_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/tts_tap_tuner.sv
// Top of the sampling tap selector: accepts probe results, runs the window
// search one position per clock, and holds the tap, retune and error state.
// Assumes inputs are synchronous to clk; TAPS_DDR <= TAPS_NORM.
module tts_tap_tuner #(
    parameter int TAPS_NORM = 8,
    parameter int TAPS_DDR  = 4,
    parameter int MIN_RUN   = 3,
    localparam int TW       = $clog2(TAPS_NORM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sweep_begin,
    input  logic          mode_ddr,
    input  logic          res_valid,
    input  logic          res_pass,
    input  logic          select_go,
    input  logic          err_in,
    input  logic          err_clr,
    output logic          busy,
    output logic          done,
    output logic          tune_ok,
    output logic [TW-1:0] tap_sel,
    output logic          retune_en,
    output logic          err_flag
);
    import tts_pkg::*;

    localparam int            CW     = $clog2(2*TAPS_NORM+1);
    localparam logic [CW-1:0] SPAN_N = CW'(2*TAPS_NORM);
    localparam logic [CW-1:0] SPAN_D = CW'(2*TAPS_DDR);
    localparam logic [CW-1:0] MINR   = CW'(MIN_RUN);

    tts_state_e    state;
    logic [CW-1:0] idx, wptr, span, win_len;
    logic [TW-1:0] centre;
    logic          ddr_q, idle, take_begin, take_wr, take_go, cur_good;

    always_comb begin
        span       = ddr_q ? SPAN_D : SPAN_N;
        idle       = (state == ST_IDLE);
        take_begin = idle && sweep_begin;
        take_wr    = idle && !sweep_begin && res_valid && (wptr < span);
        take_go    = idle && !sweep_begin && select_go;
        busy       = !idle;
    end

    // Sweep bookkeeping: mode latch and result write position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ddr_q <= 1'b0;
            wptr  <= '0;
        end else if (take_begin) begin
            ddr_q <= mode_ddr;
            wptr  <= '0;
        end else if (take_wr) begin
            wptr  <= wptr + 1'b1;
        end
    end

    // Search sequencer: scan 2N positions, then one closing cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (take_go) begin
                    state <= ST_SCAN;
                    idx   <= '0;
                end
                ST_SCAN: if (idx == span - 1'b1) begin
                    state <= ST_FIN;
                end else begin
                    idx <= idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result registers, updated as the search closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            tune_ok <= 1'b0;
            tap_sel <= '0;
        end else begin
            done <= (state == ST_FIN);
            if (state == ST_FIN) begin
                tune_ok <= (win_len >= MINR);
                if (win_len >= MINR) begin
                    tap_sel <= centre;
                end
            end
        end
    end

    tts_bitmap #(.TAPS_NORM(TAPS_NORM), .TAPS_DDR(TAPS_DDR), .CW(CW)) u_map (
        .clk(clk), .rst_n(rst_n), .clr(take_begin), .wr_en(take_wr),
        .wr_idx(wptr), .wr_bit(res_pass), .ddr(ddr_q), .rd_idx(idx),
        .rd_good(cur_good)
    );

    tts_scan #(.TAPS_NORM(TAPS_NORM), .TAPS_DDR(TAPS_DDR), .CW(CW), .TW(TW)) u_scan (
        .clk(clk), .rst_n(rst_n), .clr(take_go), .step(state == ST_SCAN),
        .bit_in(cur_good), .idx(idx), .ddr(ddr_q), .win_len(win_len),
        .centre(centre)
    );

    tts_retune u_rt (
        .clk(clk), .rst_n(rst_n), .clr_en(take_begin),
        .set_en((state == ST_FIN) && (win_len >= MINR)), .ddr(ddr_q),
        .err_in(err_in), .err_clr(err_clr), .retune_en(retune_en),
        .err_flag(err_flag)
    );
endmodule

// File: rtl/tts_checker.sv
// Port-level temporal checks for the tap selector, bound into every instance.
module tts_checker #(
    parameter int TW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          tune_ok,
    input logic [TW-1:0] tap_sel,
    input logic          retune_en,
    input logic          err_in,
    input logic          err_clr,
    input logic          err_flag
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R4
    AST_PASS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tune_ok) |-> retune_en); // R6
    AST_FAIL_KEEPS_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !tune_ok) |-> $stable(tap_sel)); // R7
    AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> ($past(err_in) && $past(retune_en))); // R8
    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !err_in) |=> !err_flag); // R9
endmodule

bind tts_tap_tuner tts_checker #(.TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .tune_ok(tune_ok),
    .tap_sel(tap_sel), .retune_en(retune_en), .err_in(err_in),
    .err_clr(err_clr), .err_flag(err_flag)
);

// File: tb/tts_tap_tuner_bench.sv
module tts_tap_tuner_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sweep_begin = 1'b0, mode_ddr = 1'b0, res_valid = 1'b0;
    logic       res_pass = 1'b0, select_go = 1'b0, err_in = 1'b0, err_clr = 1'b0;
    logic       busy, done, tune_ok, retune_en, err_flag;
    logic [2:0] tap_sel;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // reference model state
    int  m_raw[16];
    int  m_wptr = 0, m_mode = 0, m_cnt = 0, m_tap = 0;
    int  m_done = 0, m_ok = 0, m_ren = 0, m_err = 0;
    int  p_ok = 0, p_tap = 0;

    always #10 clk = ~clk;

    tts_tap_tuner u_tts_tap_tuner (
        .clk(clk), .rst_n(rst_n), .sweep_begin(sweep_begin), .mode_ddr(mode_ddr),
        .res_valid(res_valid), .res_pass(res_pass), .select_go(select_go),
        .err_in(err_in), .err_clr(err_clr), .busy(busy), .done(done),
        .tune_ok(tune_ok), .tap_sel(tap_sel), .retune_en(retune_en),
        .err_flag(err_flag)
    );

    // Expected outcome of a search over the current model results
    task automatic predict(output int ok, output int tap);
        int n, best, bst, len;
        int good[16];
        n = m_mode ? 4 : 8;
        best = 0; bst = 0;
        for (int i = 0; i < 2*n; i++) good[i] = m_raw[i % n] & m_raw[(i % n) + n];
        for (int i = 0; i < 2*n; i++) begin
            if (good[i] == 1 && (i == 0 || good[i-1] == 0)) begin
                len = 0;
                for (int j = i; j < 2*n && good[j] == 1; j++) len++;
                if (len > best) begin best = len; bst = i; end
            end
        end
        ok  = (best >= 3) ? 1 : 0;
        tap = ((bst + bst + best - 1) / 2) % n;
    endtask

    // Cycle model advanced on every rising edge
    always @(posedge clk) begin
        int old_ren, old_mode, n;
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_raw[i] = 0;
            m_wptr = 0; m_mode = 0; m_cnt = 0; m_tap = 0;
            m_done = 0; m_ok = 0; m_ren = 0; m_err = 0;
        end else begin
            old_ren = m_ren; old_mode = m_mode;
            if (m_cnt == 0) begin
                m_done = 0;
                if (sweep_begin) begin
                    for (int i = 0; i < 16; i++) m_raw[i] = 0;
                    m_wptr = 0; m_mode = mode_ddr; m_ren = 0;
                end else begin
                    n = m_mode ? 4 : 8;
                    if (res_valid && m_wptr < 2*n) begin
                        m_raw[m_wptr] = res_pass; m_wptr++;
                    end
                    if (select_go) begin
                        predict(p_ok, p_tap);
                        m_cnt = 2*n + 1;
                    end
                end
            end else begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1; m_ok = p_ok;
                    if (p_ok == 1) begin m_tap = p_tap; m_ren = 1; end
                end
            end
            if (err_in && old_ren == 1 && old_mode == 0) m_err = 1;
            else if (err_clr) m_err = 0;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cyc > 2) begin
            chk("R4", "busy", busy, (m_cnt != 0) ? 1 : 0);
            chk("R4", "done", done, m_done);
            chk("R6", "tune_ok", tune_ok, m_ok);
            chk("R6", "tap_sel", tap_sel, m_tap);
            chk("R6", "retune_en", retune_en, m_ren);
            chk("R8", "err_flag", err_flag, m_err);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc >= 150000) begin
            fails++;
            $display("FAIL R4 watchdog: got %0d expected %0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    task automatic load(input bit ddr, input logic [7:0] s1, input logic [7:0] s2, input int extra);
        int n;
        n = ddr ? 4 : 8;
        @(negedge clk); sweep_begin = 1; mode_ddr = ddr;
        @(negedge clk); sweep_begin = 0; mode_ddr = 0;
        for (int i = 0; i < 2*n + extra; i++) begin
            res_valid = 1;
            res_pass  = (i < n) ? s1[i] : ((i < 2*n) ? s2[i-n] : 1'b0);
            @(negedge clk);
        end
        res_valid = 0; res_pass = 0;
    endtask

    task automatic go_wait;
        select_go = 1;
        @(negedge clk); select_go = 0;
        while (!done) @(negedge clk);
    endtask

    task automatic result(input string tag, input int ok, input int tap, input int ren);
        chk(tag, "tune_ok", tune_ok, ok);
        chk(tag, "tap_sel", tap_sel, tap);
        chk(tag, "retune_en", retune_en, ren);
    endtask

    task automatic pulse_err(input bit e, input bit c);
        err_in = e; err_clr = c;
        @(negedge clk); err_in = 0; err_clr = 0;
        @(negedge clk);
    endtask

    initial begin
        int ok, tap;
        logic [7:0] s1, s2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "busy", busy, 0);      chk("R1", "done", done, 0);
        chk("R1", "tune_ok", tune_ok, 0); chk("R1", "tap_sel", tap_sel, 0);
        chk("R1", "retune_en", retune_en, 0); chk("R1", "err_flag", err_flag, 0);

        load(0, 8'hFF, 8'hFF, 0); go_wait(); result("R5", 1, 7, 1);
        load(0, 8'b0111_1100, 8'b0011_1110, 0); go_wait(); result("R3", 1, 3, 1);
        load(0, 8'hFF, 8'b0000_0011, 0); go_wait(); result("R7", 0, 3, 0);
        load(0, 8'b1110_0001, 8'b1110_0001, 0); go_wait(); result("R5", 1, 6, 1);
        load(0, 8'b0011_1000, 8'b0011_1000, 0); go_wait(); result("R6", 1, 4, 1);
        load(0, 8'b0111_0111, 8'b0111_0111, 0); go_wait(); result("R5", 1, 1, 1);
        load(1, 8'h0F, 8'h0F, 0); go_wait(); result("R6", 1, 3, 1);
        load(1, 8'h06, 8'h06, 0); go_wait(); result("R7", 0, 3, 0);
        load(1, 8'h0D, 8'h0D, 4); go_wait(); result("R2", 1, 3, 1);

        // DDR mode with retune on: error ignored
        pulse_err(1, 0); chk("R8", "err_flag", err_flag, 0);
        // new eight-tap sweep, retune off: error ignored
        load(0, 8'hFF, 8'hFF, 0); pulse_err(1, 0); chk("R8", "err_flag", err_flag, 0);
        go_wait(); result("R6", 1, 7, 1);
        pulse_err(1, 0); chk("R8", "err_flag", err_flag, 1);
        pulse_err(0, 1); chk("R9", "err_flag", err_flag, 0);
        pulse_err(1, 1); chk("R9", "err_flag", err_flag, 1);
        pulse_err(0, 1); chk("R9", "err_flag", err_flag, 0);

        // R10: strobes during a search are ignored
        load(0, 8'b0001_1110, 8'b0001_1110, 0);
        select_go = 1; @(negedge clk); select_go = 0;
        repeat (3) @(negedge clk);
        sweep_begin = 1; mode_ddr = 1; res_valid = 1; res_pass = 0; select_go = 1;
        @(negedge clk);
        sweep_begin = 0; mode_ddr = 0; res_valid = 0; select_go = 0;
        while (!done) @(negedge clk);
        result("R10", 1, 2, 1);
        go_wait(); result("R10", 1, 2, 1);

        // random sweeps
        for (int k = 0; k < 30; k++) begin
            bit d;
            d  = 1'($urandom % 2);
            s1 = 8'($urandom);
            s2 = (k % 3 == 0) ? 8'($urandom) : s1;
            load(d, s1, s2, 0);
            predict(ok, tap);
            go_wait();
            chk("R5", "tune_ok", tune_ok, ok);
            if (ok == 1) chk("R6", "tap_sel", tap_sel, tap);
        end

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule